// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns one packed command word, written by a host, into a complete transaction on a raw 8-bit NAND flash bus. It emits the opening command byte with the command latch raised. It then sends zero to five address bytes with the address latch raised, and after them an optional closing command byte. While the sequence runs, it holds exactly one chip-select line low.

After the last bus write, the sequencer waits for the device's ready/busy line to go high. It then issues a status command and reads one status byte, and it keeps doing so until the ready bit in that byte is set. At that point it gives a single-cycle done pulse and a sticky error flag, and it returns to idle.

The host can start a new command only while `busy` is low. The sequencer latches the command word and the address registers when it accepts the command, so the host may change them while a sequence is in flight. An erase is simply a command word with row bytes only and the closing-command flag set.

Top module: `nand_seq`

## Requirements
- R1: The command word fields are:
  - opening command byte in bits 9:2
  - closing command byte in bits 17:10
  - closing-command-valid flag in bit 18
  - address-byte count in bits 21:19
  - chip select in bits 24:22
  - data-phase enable in bit 25
  - direction in bit 26 (1 = write, 0 = read)
- R2: A `start` seen while idle is accepted, and `busy` is high on the following cycle. `busy` stays high until the done cycle. A `start` given while `busy` is high is ignored.
- R3: Bus writes occur in this order: the opening command with `cle`, then the address bytes with `ale`, then the closing command with `cle` only when bit 18 is set.
- R4: Address bytes go out least significant first. For counts 1 to 4, byte k is bits 8k+7:8k of `addr_c1234`. For a count of 5, the first byte is `addr_c0` and the next four are `addr_c1234` bytes 0 to 3.
- R5: Each bus write drives its latch with `we_n` low for exactly STROBE clocks (default 2), followed by one clock with `we_n` high and both latches low.
- R6: While `busy` is high, only `cs_n[chip select]` is low. While idle, all `cs_n` lines are high.
- R7: After the last command or address write, no status command is issued while `rb_n` is low.
- R8: The status phase writes the status opcode 0x70 with `cle`, then reads one byte with `re_n` low for STROBE clocks and `dq_oe` low. It repeats both steps until bit 6 of the byte is set.
- R9: `done` is a one-cycle pulse. At that pulse, `err` equals the final status bit 0, ORed with the illegal-count error. `err` then holds until the next accepted `start`, which clears it.
- R10: An address count of 6 or 7 sets `err` and sends no address bytes. The command bytes and the status phase still run.
- R11: While `busy` is high, `data_en` and `write_dir` reflect bits 25 and 26 of the accepted word. Both are 0 while idle.
- R12: After reset, the outputs are:
  - `busy`, `done`, `err`, `cle` and `ale` are 0
  - `we_n` and `re_n` are 1
  - all `cs_n` lines are 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to accept `cmd_word` |
| cmd_word | input | 32 | Packed command word |
| addr_c0 | input | 8 | First address byte when five are used |
| addr_c1234 | input | 32 | Packed address bytes, lowest first |
| busy | output | 1 | Sequence in flight |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky failure or illegal-count flag |
| data_en | output | 1 | Data phase requested by the accepted word |
| write_dir | output | 1 | Direction of the accepted word (1 = write) |
| cs_n | output | NCS | Active-low chip selects |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Bus byte driven toward the device |
| dq_oe | output | 1 | Output enable for `dq_out` |
| dq_in | input | 8 | Bus byte from the device |
| rb_n | input | 1 | Device ready (1) or busy (0) |

## Verification
A wrong state register or a wrong address index shows up on the bus within one write slot: a missing, repeated or reordered latch byte, or a closing command that appears without its flag. A wrong strobe counter appears at the first rising edge of `we_n` or `re_n` as a pulse of the wrong width. A wrong poll-exit decision shows up in two ways: `done` either arrives while the status byte still says not-ready, or never arrives once it says ready. A wrong chip-select decode or a stale error bit is visible as soon as `busy` rises or `done` pulses.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    // Field positions inside the packed command word
    localparam int OP1_LSB   = 2;
    localparam int OP2_LSB   = 10;
    localparam int OP2_OK    = 18;
    localparam int NADDR_LSB = 19;
    localparam int CHIP_LSB  = 22;
    localparam int DATA_BIT  = 25;
    localparam int WR_BIT    = 26;
    localparam int MAX_ADDR  = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD1,
        S_ADDR,
        S_CMD2,
        S_WAITRB,
        S_STCMD,
        S_STREAD,
        S_DONE
    } nseq_state_e;

    typedef struct packed {
        logic [7:0] op1;
        logic [7:0] op2;
        logic       op2_ok;
        logic [2:0] n_addr;
        logic [2:0] chip;
        logic       data_en;
        logic       wr;
    } nseq_cmd_t;

    // Byte k of an n-byte address: a five-byte address takes its lead byte
    // from the separate register, all others come from the packed word.
    function automatic logic [7:0] addr_byte(input logic [2:0]  n,
                                             input logic [2:0]  k,
                                             input logic [7:0]  b0,
                                             input logic [31:0] b1234);
        logic [1:0] sel;
        logic [7:0] r;
        if (n == 3'd5 && k == 3'd0) begin
            r = b0;
        end else begin
            sel = (n == 3'd5) ? (k[1:0] - 2'd1) : k[1:0];
            case (sel)
                2'd0:    r = b1234[7:0];
                2'd1:    r = b1234[15:8];
                2'd2:    r = b1234[23:16];
                default: r = b1234[31:24];
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/nseq_cyc_timer.sv
module nseq_cyc_timer #(
    parameter int STROBE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic low,
    output logic sample,
    output logic last
);
    localparam int CW = $clog2(STROBE + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign low    = active && (cnt < CW'(STROBE));
    assign sample = active && (cnt == CW'(STROBE - 1));
    assign last   = active && (cnt == CW'(STROBE));
endmodule

// File: rtl/nseq_addr_pick.sv
module nseq_addr_pick (
    input  logic [2:0]  n_addr,
    input  logic [2:0]  idx,
    input  logic [7:0]  first,
    input  logic [31:0] packed4,
    output logic [7:0]  abyte
);
    assign abyte = nseq_pkg::addr_byte(n_addr, idx, first, packed4);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nseq_pkg::*;
#(
    parameter int         STROBE    = 2,
    parameter int         NCS       = 8,
    parameter logic [7:0] STATUS_OP = 8'h70
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [31:0]    cmd_word,
    input  logic [7:0]     addr_c0,
    input  logic [31:0]    addr_c1234,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic           data_en,
    output logic           write_dir,
    output logic [NCS-1:0] cs_n,
    output logic           cle,
    output logic           ale,
    output logic           we_n,
    output logic           re_n,
    output logic [7:0]     dq_out,
    output logic           dq_oe,
    input  logic [7:0]     dq_in,
    input  logic           rb_n
);
    nseq_state_e state;
    nseq_cmd_t   cmd_in, cmd_q;
    logic [7:0]  c0_q, abyte;
    logic [31:0] c4_q;
    logic [2:0]  idx, n_eff;
    logic        st_ready, st_fail, err_q;
    logic        bad_cnt, wcyc, active, low, sample, last;
    nseq_state_e after_addr;
    logic        unused_bits;

    assign unused_bits = ^{cmd_word[1:0], cmd_word[31:27], dq_in[7], dq_in[5:1]};

    always_comb begin
        cmd_in.op1     = cmd_word[OP1_LSB +: 8];
        cmd_in.op2     = cmd_word[OP2_LSB +: 8];
        cmd_in.op2_ok  = cmd_word[OP2_OK];
        cmd_in.n_addr  = cmd_word[NADDR_LSB +: 3];
        cmd_in.chip    = cmd_word[CHIP_LSB +: 3];
        cmd_in.data_en = cmd_word[DATA_BIT];
        cmd_in.wr      = cmd_word[WR_BIT];
    end

    assign bad_cnt    = cmd_in.n_addr > 3'(MAX_ADDR);
    assign after_addr = cmd_q.op2_ok ? S_CMD2 : S_WAITRB;
    assign wcyc       = (state == S_CMD1) || (state == S_ADDR) ||
                        (state == S_CMD2) || (state == S_STCMD);
    assign active     = wcyc || (state == S_STREAD);

    nseq_cyc_timer #(.STROBE(STROBE)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .low    (low),
        .sample (sample),
        .last   (last)
    );

    nseq_addr_pick u_pick (
        .n_addr  (n_eff),
        .idx     (idx),
        .first   (c0_q),
        .packed4 (c4_q),
        .abyte   (abyte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cmd_q    <= '0;
            c0_q     <= '0;
            c4_q     <= '0;
            idx      <= '0;
            n_eff    <= '0;
            st_ready <= 1'b0;
            st_fail  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    cmd_q <= cmd_in;
                    c0_q  <= addr_c0;
                    c4_q  <= addr_c1234;
                    idx   <= '0;
                    n_eff <= bad_cnt ? 3'd0 : cmd_in.n_addr;
                    err_q <= bad_cnt;
                    state <= S_CMD1;
                end
                S_CMD1: if (last) begin
                    state <= (n_eff != 3'd0) ? S_ADDR : after_addr;
                end
                S_ADDR: if (last) begin
                    if (idx == n_eff - 3'd1) begin
                        state <= after_addr;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
                S_CMD2:   if (last) state <= S_WAITRB;
                S_WAITRB: if (rb_n) state <= S_STCMD;
                S_STCMD:  if (last) state <= S_STREAD;
                S_STREAD: begin
                    if (sample) begin
                        st_ready <= dq_in[6];
                        st_fail  <= dq_in[0];
                    end
                    if (last) begin
                        if (st_ready) begin
                            err_q <= err_q | st_fail;
                            state <= S_DONE;
                        end else begin
                            state <= S_STCMD;
                        end
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            S_CMD1:  dq_out = cmd_q.op1;
            S_ADDR:  dq_out = abyte;
            S_CMD2:  dq_out = cmd_q.op2;
            S_STCMD: dq_out = STATUS_OP;
            default: dq_out = 8'h00;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign done      = (state == S_DONE);
    assign err       = err_q;
    assign data_en   = busy && cmd_q.data_en;
    assign write_dir = busy && cmd_q.wr;
    assign we_n      = !(wcyc && low);
    assign re_n      = !((state == S_STREAD) && low);
    assign cle       = low && ((state == S_CMD1) || (state == S_CMD2) || (state == S_STCMD));
    assign ale       = low && (state == S_ADDR);
    assign dq_oe     = wcyc;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(busy && (cmd_q.chip == 3'(g)));
    end
endmodule

// File: rtl/nseq_checker.sv
module nseq_checker #(
    parameter int NCS = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           cle,
    input logic           ale,
    input logic           we_n,
    input logic           re_n,
    input logic           dq_oe,
    input logic [NCS-1:0] cs_n
);
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n)); // R5
    AST_FALL_HAS_LATCH: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> (cle || ale)); // R5
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R2
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R2
    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(~cs_n) == 1)); // R6
    AST_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&cs_n)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_READ_HIZ: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !dq_oe); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (we_n && re_n && !cle && !ale)); // R12
endmodule

bind nand_seq nseq_checker #(.NCS(NCS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .cle   (cle),
    .ale   (ale),
    .we_n  (we_n),
    .re_n  (re_n),
    .dq_oe (dq_oe),
    .cs_n  (cs_n)
);

// File: tb/nand_seq_tb_top.sv
module nand_seq_tb_top;
    localparam int         CLK_PERIOD = 10;
    localparam int         STROBE     = 2;
    localparam int         NCS        = 8;
    localparam logic [7:0] STAT_OP    = 8'h70;

    typedef struct packed {
        logic [7:0]  op1;
        logic [7:0]  op2;
        logic        v2;
        logic [2:0]  n;
        logic [2:0]  cs;
        logic        de;
        logic        wr;
        logic [7:0]  c0;
        logic [31:0] c4;
        logic [7:0]  st;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'h00, 8'h30, 1'b1, 3'd5, 3'd0, 1'b1, 1'b0, 8'h11, 32'h5544_3322, 8'h40},
        '{8'h60, 8'hD0, 1'b1, 3'd3, 3'd3, 1'b0, 1'b0, 8'hFF, 32'h00AB_CDEF, 8'h40},
        '{8'h80, 8'h10, 1'b1, 3'd4, 3'd5, 1'b1, 1'b1, 8'h00, 32'hDEAD_BEEF, 8'h41},
        '{8'hFF, 8'h00, 1'b0, 3'd0, 3'd7, 1'b0, 1'b1, 8'h00, 32'h0000_0000, 8'h40},
        '{8'h90, 8'h00, 1'b0, 3'd1, 3'd2, 1'b1, 1'b0, 8'h00, 32'h0000_0020, 8'hC0}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [31:0]    cmd_word = '0;
    logic [7:0]     addr_c0 = '0;
    logic [31:0]    addr_c1234 = '0;
    logic           busy, done, err, data_en, write_dir;
    logic [NCS-1:0] cs_n;
    logic           cle, ale, we_n, re_n, dq_oe;
    logic [7:0]     dq_out;
    logic [7:0]     st_byte = 8'h40;
    logic           rb_n = 1'b1;

    nand_seq #(.STROBE(STROBE), .NCS(NCS), .STATUS_OP(STAT_OP)) dut_i (
        .clk(clk), .rst(rst), .start(start), .cmd_word(cmd_word),
        .addr_c0(addr_c0), .addr_c1234(addr_c1234), .busy(busy), .done(done),
        .err(err), .data_en(data_en), .write_dir(write_dir), .cs_n(cs_n),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(st_byte), .rb_n(rb_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // Bus monitor, samples at the falling clock edge
    logic [1:0]     lk [0:63];
    logic [7:0]     lb [0:63];
    int             wcnt = 0, rcnt = 0, dcnt = 0, lowrun = 0, bad_strobe = 0, bad_done = 0;
    logic           pwe = 1'b1, pre = 1'b1, pdone = 1'b0;
    logic [NCS-1:0] cs_acc = '0;
    logic           err_s = 1'b0, de_s = 1'b0, wr_s = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!we_n && pwe) begin
                if (wcnt < 64) begin
                    lk[wcnt] = {cle, ale};
                    lb[wcnt] = dq_out;
                end
                wcnt++;
            end
            if (!re_n && pre) rcnt++;
            if (!we_n || !re_n) begin
                lowrun++;
            end else begin
                if ((!pwe || !pre) && lowrun != STROBE) bad_strobe++;
                if (!pwe && (cle || ale)) bad_strobe++;
                lowrun = 0;
            end
            if (done) begin
                dcnt++;
                err_s = err;
                de_s  = data_en;
                wr_s  = write_dir;
                if (pdone) bad_done++;
            end
            if (busy) cs_acc = cs_acc | ~cs_n;
            pwe   = we_n;
            pre   = re_n;
            pdone = done;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_log();
        wcnt = 0; rcnt = 0; cs_acc = '0; bad_strobe = 0; bad_done = 0;
    endtask

    function automatic logic [31:0] mk(input vec_t v);
        return {5'b0, v.wr, v.de, v.cs, v.n, v.v2, v.op2, v.op1, 2'b00};
    endfunction

    int d0 = 0;

    task automatic issue(input vec_t v);
        tick();
        cmd_word   = mk(v);
        addr_c0    = v.c0;
        addr_c1234 = v.c4;
        d0         = dcnt;
        start      = 1'b1;
        tick();
        start = 1'b0;
        chk("R2", "busy after accept", busy, 1'b1);
    endtask

    task automatic wait_done();
        int t = 0;
        while (dcnt == d0 && t < 3000) begin
            tick();
            t++;
        end
        chk("R2", "done reached", (dcnt != d0), 1'b1);
        chk("R9", "single done pulse", bad_done, 0);
    endtask

    // Expected bus writes, built from R3, R4, R8 and R10
    logic [1:0] ek [0:15];
    logic [7:0] eb [0:15];
    int         en;

    task automatic push(input logic [1:0] k, input logic [7:0] b);
        ek[en] = k;
        eb[en] = b;
        en++;
    endtask

    task automatic expect_seq(input vec_t v);
        en = 0;
        push(2'b10, v.op1);
        if (v.n <= 3'd5) begin
            for (int k = 0; k < int'(v.n); k++) begin
                if (v.n == 3'd5) push(2'b01, (k == 0) ? v.c0 : v.c4[8*(k-1) +: 8]);
                else             push(2'b01, v.c4[8*k +: 8]);
            end
        end
        if (v.v2) push(2'b10, v.op2);
        push(2'b10, STAT_OP);
    endtask

    task automatic compare_log();
        chk("R3", "bus write count", wcnt, en);
        for (int i = 0; i < en && i < wcnt; i++) begin
            chk((ek[i] == 2'b01) ? "R4" : "R3", $sformatf("write %0d latch", i), lk[i], ek[i]);
            chk((ek[i] == 2'b01) ? "R4" : "R3", $sformatf("write %0d byte", i), lb[i], eb[i]);
        end
        chk("R5", "strobe shape", bad_strobe, 0);
    endtask

    task automatic run_vec(input vec_t v);
        clear_log();
        st_byte = v.st;
        rb_n    = 1'b1;
        issue(v);
        wait_done();
        expect_seq(v);
        compare_log();
        chk("R8", "status reads", rcnt, 1);
        chk("R9", "err at done", err_s, v.st[0] | (v.n > 3'd5));
        chk("R6", "chip select", cs_acc, NCS'(1) << v.cs);
        chk("R11", "data enable", de_s, v.de);
        chk("R1", "direction", wr_s, v.wr);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R12 reset state
        chk("R12", "busy", busy, 0);
        chk("R12", "done", done, 0);
        chk("R12", "err", err, 0);
        chk("R12", "cs_n", cs_n, {NCS{1'b1}});
        chk("R12", "strobes", {we_n, re_n, cle, ale}, 4'b1100);

        // Table walk: R1 R3 R4 R5 R6 R8 R9 R11
        for (int i = 0; i < 5; i++) run_vec(VECS[i]);

        // R9 sticky error, then cleared by the next accepted command
        run_vec(VECS[2]);
        repeat (5) tick();
        chk("R9", "err sticky while idle", err, 1);
        run_vec(VECS[3]);
        chk("R9", "err cleared by new command", err, 0);

        // R10 illegal address counts
        v = '{8'h85, 8'h10, 1'b1, 3'd6, 3'd1, 1'b0, 1'b1, 8'h12, 32'h1234_5678, 8'h40};
        run_vec(v);
        v.n = 3'd7;
        v.v2 = 1'b0;
        run_vec(v);
        chk("R10", "err after illegal count", err, 1);

        // R7 ready wait, and R2 start ignored while busy
        clear_log();
        st_byte = 8'h40;
        rb_n    = 1'b0;
        v = '{8'hEE, 8'h00, 1'b0, 3'd0, 3'd4, 1'b0, 1'b0, 8'h00, 32'h0, 8'h40};
        issue(v);
        repeat (10) tick();
        cmd_word = mk('{8'h33, 8'h00, 1'b0, 3'd0, 3'd6, 1'b0, 1'b0, 8'h00, 32'h0, 8'h40});
        start    = 1'b1;
        tick();
        start = 1'b0;
        repeat (20) tick();
        chk("R7", "no status while device busy", wcnt, 1);
        chk("R7", "still busy", busy, 1);
        rb_n = 1'b1;
        wait_done();
        expect_seq(v);
        compare_log();
        chk("R2", "ignored start left chip select", cs_acc, NCS'(1) << 4);
        tick();
        chk("R2", "no second sequence", busy, 0);

        // R8 polling until ready bit set
        clear_log();
        st_byte = 8'h00;
        v = '{8'hDD, 8'h00, 1'b0, 3'd0, 3'd2, 1'b0, 1'b0, 8'h00, 32'h0, 8'h00};
        issue(v);
        repeat (40) tick();
        chk("R8", "no done while not ready", (dcnt == d0), 1);
        chk("R8", "repeated status reads", (rcnt >= 2), 1);
        st_byte = 8'h40;
        wait_done();
        chk("R8", "status writes match reads", wcnt, rcnt + 1);
        chk("R9", "err clear on ready", err_s, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule